// File: doc/BRIEF.md
# Segment Access Permission Checker

This block sits between address generation and the memory port. It takes one access request together with the cached descriptor of the segment being used, and decides whether the access may proceed. A request can be a data read, an instruction fetch or a write, with an offset into the segment and a size of 1, 2 or 4 bytes. The block checks the request against the segment bound. In protected mode it also checks descriptor presence, privilege, and whether the segment type allows that kind of access.

Every request strobe produces exactly one registered answer one cycle later. The answer is either a grant, together with the linear address (segment base plus offset), or a fault, together with a 2-bit class: general protection or segment not present. The checks are prioritised, so a request that breaks several rules reports only the one with the highest priority. Loading descriptors, paging and the memory itself are handled elsewhere.

Top module: `seg_access_checker`

## Requirements
- R1: An access whose last byte, offset + size - 1, lies above the segment limit faults with class 1 (general protection). This holds whether or not protected mode is enabled.
- R2: The last-byte sum is formed one bit wider than the offset, so a sum that passes 2^32 counts as over the limit even when the limit is all ones.
- R3: With the protected-mode enable low, only the bound check applies. Presence, privilege and type fields have no effect on the result.
- R4: In protected mode, a descriptor whose present bit is clear faults with class 2 (not present).
- R5: In protected mode, a data read (kind code 0) or a write (kind code 2) faults with class 1 when the requester level exceeds the descriptor level. An instruction fetch (kind code 1) ignores this rule.
- R6: In protected mode, any access kind faults with class 1 when the current level exceeds the descriptor level.
- R7: In protected mode, a fetch from a segment whose executable bit is clear faults with class 1.
- R8: In protected mode, a data read from an executable segment whose read/write bit is clear faults with class 1. A kind code of 3 is handled as a data read.
- R9: In protected mode, a write to an executable segment faults with class 1. A write to a data segment whose read/write bit is clear also faults with class 1.
- R10: The checks have a fixed priority: bound first, then presence, then privilege, then type. Only the first one that fails sets the class.
- R11: On every answer, the linear address output equals base + offset, truncated to 32 bits, taken from the request cycle.
- R12: For a request strobe in cycle n, exactly one of grant or fault is high for one cycle in cycle n+1. Neither is high in a cycle that follows a cycle without a request.
- R13: The fault class reads 0 on a grant and in idle cycles, and is nonzero together with fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 data read, 1 instruction fetch, 2 write, 3 treated as read |
| req_offset | input | 32 | Offset into the segment |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| pe_en | input | 1 | Protected-mode enable |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 32 | Highest valid offset |
| desc_present | input | 1 | Descriptor present |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_rpl | input | 2 | Requester privilege level of the selector |
| desc_exec | input | 1 | Segment is executable (code) |
| desc_rw | input | 1 | Readable for code, writable for data |
| cpl | input | 2 | Current privilege level |
| lin_addr | output | 32 | Registered linear address |
| grant | output | 1 | Access granted, one-cycle pulse |
| fault | output | 1 | Access refused, one-cycle pulse |
| fault_class | output | 2 | 0 none, 1 general protection, 2 not present |

## Verification
The hardest cases to reach are those where several rules fail at once, because only the priority order decides the reported class. Examples are a non-present descriptor combined with an overflowing span, or a non-present descriptor combined with a privilege violation. The bench builds these on purpose. It also builds a span that wraps past 2^32 against an all-ones limit, which the narrow sum would miss. Requests are issued back to back so that each answer must line up with its own request, with no gap cycle to hide a slip.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } flt_class_e;

  // Last byte touched by an access, one bit wider than the offset.
  function automatic logic [32:0] span_last(input logic [31:0] off,
                                            input logic [2:0]  size);
    return {1'b0, off} + {30'd0, size} - 33'd1;
  endfunction

  // Linear address, truncated to the address width.
  function automatic logic [31:0] linear_of(input logic [31:0] base,
                                            input logic [31:0] off);
    return base + off;
  endfunction

endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] limit,
  output logic              over_limit
);
  localparam int SPAN_W = ADDR_W + 1;

  logic [SPAN_W-1:0] last_byte;

  always_comb begin
    last_byte  = {1'b0, offset} + SPAN_W'(size) - SPAN_W'(1);
    over_limit = last_byte > {1'b0, limit};
  end
endmodule

// File: rtl/seg_perm_chk.sv
module seg_perm_chk
  import seg_chk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic [1:0]      kind,
  input  logic            present,
  input  logic [PL_W-1:0] dpl,
  input  logic [PL_W-1:0] rpl,
  input  logic [PL_W-1:0] cur_pl,
  input  logic            exec,
  input  logic            rw,
  output logic            np_viol,
  output logic            priv_viol,
  output logic            type_viol
);
  logic is_fetch, is_write;

  always_comb begin
    is_fetch  = (kind == ACC_FETCH);
    is_write  = (kind == ACC_WRITE);
    np_viol   = !present;
    priv_viol = (cur_pl > dpl) || (!is_fetch && (rpl > dpl));
    if (is_fetch)      type_viol = !exec;
    else if (is_write) type_viol = exec || !rw;
    else               type_viol = exec && !rw;
  end
endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [1:0]        cls_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              grant_q,
  output logic              fault_q,
  output logic [1:0]        cls_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
      cls_q   <= FLT_NONE;
      addr_q  <= '0;
    end else begin
      grant_q <= take && (cls_in == FLT_NONE);
      fault_q <= take && (cls_in != FLT_NONE);
      cls_q   <= take ? cls_in : FLT_NONE;
      if (take) addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int PL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              pe_en,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] desc_limit,
  input  logic              desc_present,
  input  logic [PL_W-1:0]   desc_dpl,
  input  logic [PL_W-1:0]   desc_rpl,
  input  logic              desc_exec,
  input  logic              desc_rw,
  input  logic [PL_W-1:0]   cpl,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              grant,
  output logic              fault,
  output logic [1:0]        fault_class
);
  // Named internal events, visible to the bound checker.
  logic              over_limit;
  logic              np_viol;
  logic              priv_viol;
  logic              type_viol;
  logic [1:0]        cls_next;
  logic [ADDR_W-1:0] addr_next;

  seg_limit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) limit_i (
    .offset    (req_offset),
    .size      (req_size),
    .limit     (desc_limit),
    .over_limit(over_limit)
  );

  seg_perm_chk #(.PL_W(PL_W)) perm_i (
    .kind     (req_kind),
    .present  (desc_present),
    .dpl      (desc_dpl),
    .rpl      (desc_rpl),
    .cur_pl   (cpl),
    .exec     (desc_exec),
    .rw       (desc_rw),
    .np_viol  (np_viol),
    .priv_viol(priv_viol),
    .type_viol(type_viol)
  );

  // Priority cascade: bound, presence, privilege, type.
  always_comb begin
    addr_next = desc_base + req_offset;
    if (over_limit)     cls_next = FLT_GP;
    else if (!pe_en)    cls_next = FLT_NONE;
    else if (np_viol)   cls_next = FLT_NP;
    else if (priv_viol) cls_next = FLT_GP;
    else if (type_viol) cls_next = FLT_GP;
    else                cls_next = FLT_NONE;
  end

  seg_result_reg #(.ADDR_W(ADDR_W)) out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (req_valid),
    .cls_in (cls_next),
    .addr_in(addr_next),
    .grant_q(grant),
    .fault_q(fault),
    .cls_q  (fault_class),
    .addr_q (lin_addr)
  );
endmodule

// File: rtl/seg_access_checker_sva.sv
module seg_access_checker_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              pe_en,
  input logic              desc_present,
  input logic [ADDR_W-1:0] desc_base,
  input logic [ADDR_W-1:0] req_offset,
  input logic              over_limit,
  input logic [ADDR_W-1:0] lin_addr,
  input logic              grant,
  input logic              fault,
  input logic [1:0]        fault_class
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, fault}));

  p_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || fault));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !fault));

  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && over_limit) |=> (fault && fault_class == 2'd1));

  p_real_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pe_en && !over_limit) |=> grant);

  p_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pe_en && !over_limit && !desc_present) |=> (fault && fault_class == 2'd2));

  p_grant_cls_r13: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (fault_class == 2'd0));

  p_fault_cls_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_class != 2'd0));

  p_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (lin_addr == $past(desc_base + req_offset)));
endmodule

bind seg_access_checker seg_access_checker_sva #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .pe_en       (pe_en),
  .desc_present(desc_present),
  .desc_base   (desc_base),
  .req_offset  (req_offset),
  .over_limit  (over_limit),
  .lin_addr    (lin_addr),
  .grant       (grant),
  .fault       (fault),
  .fault_class (fault_class)
);

// File: tb/seg_access_checker_tb_top.sv
module seg_access_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_offset = '0;
  logic [2:0]  req_size = 3'd1;
  logic        pe_en = 1'b0;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic        desc_present = 1'b0;
  logic [1:0]  desc_dpl = '0;
  logic [1:0]  desc_rpl = '0;
  logic        desc_exec = 1'b0;
  logic        desc_rw = 1'b0;
  logic [1:0]  cpl = '0;
  logic [31:0] lin_addr;
  logic        grant;
  logic        fault;
  logic [1:0]  fault_class;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit live = 0;

  typedef struct {
    int          due;
    logic [1:0]  cls;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  seg_access_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_offset(req_offset), .req_size(req_size), .pe_en(pe_en),
    .desc_base(desc_base), .desc_limit(desc_limit), .desc_present(desc_present),
    .desc_dpl(desc_dpl), .desc_rpl(desc_rpl), .desc_exec(desc_exec),
    .desc_rw(desc_rw), .cpl(cpl), .lin_addr(lin_addr), .grant(grant),
    .fault(fault), .fault_class(fault_class)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Reference decision, stated from the requirements.
  function automatic logic [1:0] ref_class(input logic [1:0] k, input logic [31:0] off,
      input logic [2:0] sz, input logic pe, input logic [31:0] lim, input logic p,
      input logic [1:0] dpl, input logic [1:0] rpl, input logic [1:0] cp,
      input logic ex, input logic rw);
    longint unsigned last;
    bit bad_type;
    last = longint'(off) + longint'(sz) - 1;
    if (last > longint'(lim)) return 2'd1;      // R1/R2
    if (!pe) return 2'd0;                         // R3
    if (!p) return 2'd2;                          // R4
    if (cp > dpl) return 2'd1;                    // R6
    if (k != 2'd1 && rpl > dpl) return 2'd1;      // R5
    case (k)
      2'd1:    bad_type = !ex;                    // R7
      2'd2:    bad_type = ex || !rw;              // R9
      default: bad_type = ex && !rw;              // R8
    endcase
    return bad_type ? 2'd1 : 2'd0;
  endfunction

  task automatic send(input logic [1:0] k, input logic [31:0] off, input logic [2:0] sz,
      input logic pe, input logic [31:0] base, input logic [31:0] lim, input logic p,
      input logic [1:0] dpl, input logic [1:0] rpl, input logic [1:0] cp,
      input logic ex, input logic rw, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_offset = off; req_size = sz; pe_en = pe;
    desc_base = base; desc_limit = lim; desc_present = p; desc_dpl = dpl;
    desc_rpl = rpl; cpl = cp; desc_exec = ex; desc_rw = rw;
    e.due = cyc + 1;
    e.cls = ref_class(k, off, sz, pe, lim, p, dpl, rpl, cp, ex, rw);
    e.addr = base + off;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compares each answer with the queued expectation.
  always @(negedge clk) begin
    #1;
    if (live && !done) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (grant !== (e.cls == 2'd0) || fault !== (e.cls != 2'd0) || fault_class !== e.cls) begin
          errors++;
          $display("FAIL %s: grant=%b fault=%b class=%0d expected class=%0d",
                   e.tag, grant, fault, fault_class, e.cls);
        end
        checks++;
        if (lin_addr !== e.addr) begin
          errors++;
          $display("FAIL R11 (%s): lin_addr=%h expected %h", e.tag, lin_addr, e.addr);
        end
      end else begin
        checks++;
        if (grant !== 1'b0 || fault !== 1'b0 || fault_class !== 2'd0) begin
          errors++;
          $display("FAIL R12/R13 idle: grant=%b fault=%b class=%0d expected 0 0 0",
                   grant, fault, fault_class);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== 1'b0 || fault !== 1'b0 || fault_class !== 2'd0 || lin_addr !== 32'd0) begin
      errors++;
      $display("FAIL R12 reset: grant=%b fault=%b class=%0d addr=%h expected 0 0 0 0",
               grant, fault, fault_class, lin_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    idle(2);

    // kind: 0 read, 1 fetch, 2 write, 3 as read
    // R1 bound in real and protected mode
    send(2'd0, 32'h0000_00FC, 3'd4, 1'b0, 32'h1000, 32'hFF, 1, 0, 0, 0, 0, 1, "R1 fit");
    send(2'd0, 32'h0000_00FD, 3'd4, 1'b0, 32'h1000, 32'hFF, 1, 0, 0, 0, 0, 1, "R1 over real");
    send(2'd2, 32'h0000_00FF, 3'd2, 1'b1, 32'h1000, 32'hFF, 1, 3, 0, 0, 0, 1, "R1 over prot");
    send(2'd1, 32'h0000_00FF, 3'd1, 1'b1, 32'h1000, 32'hFF, 1, 3, 0, 0, 1, 0, "R1 last byte");
    // R2 wraparound
    send(2'd0, 32'hFFFF_FFFF, 3'd2, 1'b0, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, "R2 wrap");
    send(2'd0, 32'hFFFF_FFFC, 3'd4, 1'b0, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, "R2 top fit");
    // R3 real mode ignores presence, privilege, type
    send(2'd2, 32'h10, 3'd4, 1'b0, 32'h2000, 32'hFFFF, 0, 0, 3, 3, 1, 0, "R3 ignore");
    idle(1);
    // R4 not present
    send(2'd0, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 0, 3, 0, 0, 0, 1, "R4 absent");
    // R5 requester level
    send(2'd0, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 1, 2, 0, 0, 1, "R5 read rpl");
    send(2'd2, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 1, 2, 0, 0, 1, "R5 write rpl");
    send(2'd1, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 1, 2, 0, 1, 0, "R5 fetch rpl ok");
    // R6 current level
    send(2'd1, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 1, 0, 2, 1, 1, "R6 fetch cpl");
    send(2'd0, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 2, 0, 2, 0, 1, "R6 equal ok");
    // R7 fetch type
    send(2'd1, 32'h10, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 0, 1, "R7 fetch data");
    send(2'd1, 32'h10, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 1, 0, "R7 fetch code");
    // R8 read type
    send(2'd0, 32'h10, 3'd2, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 1, 0, "R8 read exec-only");
    send(2'd0, 32'h10, 3'd2, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 1, 1, "R8 read code ok");
    send(2'd3, 32'h10, 3'd2, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 1, 0, "R8 kind3 as read");
    send(2'd0, 32'h10, 3'd2, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 0, 0, "R8 read ro data ok");
    // R9 write type
    send(2'd2, 32'h10, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 1, 1, "R9 write code");
    send(2'd2, 32'h10, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 0, 0, "R9 write ro");
    send(2'd2, 32'h10, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 0, 0, 1, "R9 write ok");
    // R10 priority
    send(2'd0, 32'hFFFF, 3'd4, 1'b1, 32'h2000, 32'hFFFF, 0, 0, 3, 3, 1, 0, "R10 bound over absent");
    send(2'd0, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 0, 0, 3, 3, 1, 0, "R10 absent over priv");
    send(2'd2, 32'h10, 3'd1, 1'b1, 32'h2000, 32'hFFFF, 1, 0, 0, 3, 1, 0, "R10 priv over type");
    // R11 address wrap
    send(2'd0, 32'h20, 3'd1, 1'b0, 32'hFFFF_FFF0, 32'hFFFF, 1, 0, 0, 0, 0, 1, "R11 addr wrap");
    idle(1);
    send(2'd1, 32'h1234, 3'd2, 1'b1, 32'hA000_0000, 32'hFFFF, 1, 3, 3, 3, 1, 0, "R13 grant class");
    idle(4);

    done = 1;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d answers missing, expected 0", expq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule